// File: doc/BRIEF.md
# Multiframe Clock Generator with SYSREF Alignment

This block generates the local multiframe timing for one end of a serial converter link. It runs on the octet clock. Two programmable values set the timing: F is the number of octets in a frame and K is the number of frames in a multiframe. From these the block counts octets and frames. It drives a one-cycle frame-start pulse, a one-cycle multiframe-start pulse and a multiframe clock that is high for the first half of each multiframe. One multiframe lasts F × K octet-clock cycles.

An asynchronous SYSREF input passes through a synchronizer, and its rising edge moves the counters to a fixed phase. This gives a deterministic timing reference that every device in the system shares. The block checks that K is legal for the chosen F. If the pair is illegal, it raises an error and holds the generator idle. Once the block is locked, a SYSREF edge that would move the phase sets a sticky misalignment flag, which shows that a periodic SYSREF is not a whole number of multiframes long. An ignore control lets a free-running SYSREF align the block once and then only be watched.

All pins are plain control and status signals. No data stream passes through the block, so there is no back-pressure.

Top module: `mfc_gen`

## Requirements
- R1: `cfg_err` is high, combinationally from the current `cfg_f` and `cfg_k`, exactly when any of the following holds: F is 0, F is above 256, K is 0, K is above 256, K < ceil(17/F), or K > floor(1024/F).
- R2: While `cfg_err` is high, `frame_start`, `mf_start` and `mf_clk` stay low and the counters are held at the start of a multiframe. A SYSREF edge has no effect and `locked` reads 0 from the next cycle.
- R3: With a legal configuration, `frame_start` is high for one cycle at octet position 0 of each frame, once every F cycles.
- R4: `mf_start` is high for one cycle once every F × K cycles, and only in a cycle where `frame_start` is also high.
- R5: With p the octet position inside the multiframe (0 at `mf_start`), `mf_clk` is high exactly when p < floor(F × K / 2).
- R6: `sysref_in` passes through a two-flop synchronizer and only its rising edge is used. If `sysref_in` is first sampled high at clock edge n, the counters restart so that `mf_start` is high in the cycle after edge n+2.
- R7: A legal SYSREF rising edge sets `locked` at that same edge n+2.
- R8: A SYSREF rising edge while locked sets the sticky `misalign` flag when it lands anywhere except the last octet of a multiframe. A SYSREF whose period is a whole number of multiframes, counted from the aligning edge, leaves `misalign` at 0 and leaves the phase unchanged.
- R9: While `locked` and `sysref_ignore` are both high, a SYSREF edge does not move the counters. It only updates `misalign`.
- R10: `flag_clear` high at a clock edge clears `misalign`. If a misaligned SYSREF edge arrives in the same cycle, the flag is set instead.
- R11: A change of `cfg_f` or `cfg_k` clears `locked` at the next edge and restarts the counters, so that `mf_start` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_f | input | 9 | Octets per frame (F) |
| cfg_k | input | 9 | Frames per multiframe (K) |
| sysref_in | input | 1 | Asynchronous SYSREF |
| sysref_ignore | input | 1 | When locked, SYSREF only updates the misalignment flag |
| flag_clear | input | 1 | Clears the sticky misalignment flag |
| frame_start | output | 1 | One-cycle pulse at the first octet of each frame |
| mf_start | output | 1 | One-cycle pulse at the first octet of each multiframe |
| mf_clk | output | 1 | Multiframe clock, high for the first half of each multiframe |
| cfg_err | output | 1 | The F/K pair is illegal |
| locked | output | 1 | The counters have been aligned by SYSREF |
| misalign | output | 1 | Sticky: a SYSREF edge arrived off the multiframe boundary |

## Verification
An exhaustive grid of small F and K values, together with the corner products 16, 17, 1024 and 1025 and values above 256, separates a product-based legality rule from the ceiling and floor bounds it replaces. Free-running sweeps over several legal pairs with even and odd multiframe lengths test the frame pulses, multiframe pulses and clock duty against an arithmetic position model. A periodic SYSREF whose period equals the multiframe length is compared with single SYSREF edges placed mid-multiframe. This separates "aligned, no phase move" from "misaligned, flag and move", with and without the ignore control. A clear that arrives in the same cycle as a flag set, and a change of F or K while locked, test the priority and unlock rules.

// File: rtl/mfc_pkg.sv
`timescale 1ns/1ps
package mfc_pkg;
  // Legal ranges for the frame and multiframe sizes
  localparam int unsigned MAX_F    = 256;
  localparam int unsigned MAX_K    = 256;
  // Bounds on the multiframe length in octets (F*K)
  localparam int unsigned MIN_SPAN = 17;
  localparam int unsigned MAX_SPAN = 1024;
  // Width needed for a position inside the longest multiframe, plus one
  localparam int unsigned POS_W    = $clog2(MAX_SPAN) + 1;
endpackage

// File: rtl/mfc_cfg_check.sv
`timescale 1ns/1ps
module mfc_cfg_check
  import mfc_pkg::*;
#(
  parameter int CFG_W  = 9,
  localparam int PROD_W = 2 * CFG_W
) (
  input  logic [CFG_W-1:0]  f_val,
  input  logic [CFG_W-1:0]  k_val,
  output logic              legal,
  output logic [PROD_W-1:0] span
);
  logic f_ok, k_ok, span_ok;

  // Multiframe length in octets; the ceil/floor bounds become product bounds
  assign span    = PROD_W'(f_val) * PROD_W'(k_val);
  assign f_ok    = (f_val != '0) && (f_val <= CFG_W'(MAX_F));
  assign k_ok    = (k_val != '0) && (k_val <= CFG_W'(MAX_K));
  assign span_ok = (span >= PROD_W'(MIN_SPAN)) && (span <= PROD_W'(MAX_SPAN));
  assign legal   = f_ok && k_ok && span_ok;
endmodule

// File: rtl/mfc_sysref_sync.sv
`timescale 1ns/1ps
module mfc_sysref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/mfc_phase_cnt.sv
`timescale 1ns/1ps
module mfc_phase_cnt
  import mfc_pkg::*;
#(
  parameter int CFG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             restart,
  input  logic [CFG_W-1:0] f_val,
  input  logic [CFG_W-1:0] k_val,
  output logic             oct_zero,
  output logic             at_first,
  output logic             at_last,
  output logic [POS_W-1:0] pos
);
  logic [CFG_W-1:0] oct_q, frm_q;
  logic             oct_last, frm_last;

  assign oct_last = (oct_q == f_val - CFG_W'(1));
  assign frm_last = (frm_q == k_val - CFG_W'(1));
  assign at_last  = oct_last && frm_last;
  assign oct_zero = (oct_q == '0);
  assign at_first = oct_zero && (frm_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oct_q <= '0;
      frm_q <= '0;
      pos   <= '0;
    end else if (hold || restart) begin
      oct_q <= '0;
      frm_q <= '0;
      pos   <= '0;
    end else begin
      oct_q <= oct_last ? '0 : oct_q + CFG_W'(1);
      if (oct_last) frm_q <= frm_last ? '0 : frm_q + CFG_W'(1);
      pos   <= at_last ? '0 : pos + POS_W'(1);
    end
  end
endmodule

// File: rtl/mfc_gen.sv
`timescale 1ns/1ps
module mfc_gen
  import mfc_pkg::*;
#(
  parameter int CFG_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_f,
  input  logic [CFG_W-1:0] cfg_k,
  input  logic             sysref_in,
  input  logic             sysref_ignore,
  input  logic             flag_clear,
  output logic             frame_start,
  output logic             mf_start,
  output logic             mf_clk,
  output logic             cfg_err,
  output logic             locked,
  output logic             misalign
);
  localparam int PROD_W = 2 * CFG_W;

  logic              legal;
  logic [PROD_W-1:0] span;
  logic [POS_W-1:0]  half_span;
  logic              sysref_rise;
  logic              cfg_change, seen_q;
  logic [CFG_W-1:0]  f_q, k_q;
  logic              rise_act, realign, mis_set;
  logic              oct_zero, at_first, at_last;
  logic [POS_W-1:0]  pos;

  mfc_cfg_check #(.CFG_W(CFG_W)) u_check (
    .f_val (cfg_f),
    .k_val (cfg_k),
    .legal (legal),
    .span  (span)
  );

  mfc_sysref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sysref_in),
    .rise  (sysref_rise)
  );

  // Configuration change detection against last cycle's values
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q    <= '0;
      k_q    <= '0;
      seen_q <= 1'b0;
    end else begin
      f_q    <= cfg_f;
      k_q    <= cfg_k;
      seen_q <= 1'b1;
    end
  end
  assign cfg_change = seen_q && ((cfg_f != f_q) || (cfg_k != k_q));

  // SYSREF handling
  assign rise_act = sysref_rise && legal && !cfg_change;
  assign realign  = rise_act && !(locked && sysref_ignore);
  assign mis_set  = rise_act && locked && !at_last;

  mfc_phase_cnt #(.CFG_W(CFG_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (!legal),
    .restart  (cfg_change || realign),
    .f_val    (cfg_f),
    .k_val    (cfg_k),
    .oct_zero (oct_zero),
    .at_first (at_first),
    .at_last  (at_last),
    .pos      (pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  locked <= 1'b0;
    else if (cfg_change || !legal) locked <= 1'b0;
    else if (rise_act)           locked <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          misalign <= 1'b0;
    else if (mis_set)    misalign <= 1'b1;
    else if (flag_clear) misalign <= 1'b0;
  end

  assign half_span   = POS_W'(span >> 1);
  assign cfg_err     = !legal;
  assign frame_start = legal && oct_zero;
  assign mf_start    = legal && at_first;
  assign mf_clk      = legal && (pos < half_span);
endmodule

// File: rtl/mfc_gen_chk.sv
`timescale 1ns/1ps
module mfc_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_err,
  input logic frame_start,
  input logic mf_start,
  input logic locked,
  input logic misalign,
  input logic flag_clear,
  input logic sysref_rise,
  input logic cfg_change
);
  p_idle_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !locked);

  p_mf_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> frame_start);

  p_mf_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_start && !sysref_rise && !cfg_change) |=> !mf_start);

  p_lock_on_sysref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sysref_rise && !cfg_err && !cfg_change && !locked) |=> (mf_start && locked));

  p_misalign_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign && !flag_clear) |=> misalign);

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clear && !sysref_rise) |=> !misalign);

  p_change_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (!locked && (cfg_err || mf_start)));
endmodule

bind mfc_gen mfc_gen_chk u_mfc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_err     (cfg_err),
  .frame_start (frame_start),
  .mf_start    (mf_start),
  .locked      (locked),
  .misalign    (misalign),
  .flag_clear  (flag_clear),
  .sysref_rise (sysref_rise),
  .cfg_change  (cfg_change)
);

// File: tb/tb_mfc_gen.sv
`timescale 1ns/1ps
module tb_mfc_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] cfg_f, cfg_k;
  logic       sysref_in, sysref_ignore, flag_clear;
  logic       frame_start, mf_start, mf_clk, cfg_err, locked, misalign;

  int checks = 0;
  int fails  = 0;
  int cf = 0, ck = 0, span = 0, pos_exp = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mfc_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_f(cfg_f), .cfg_k(cfg_k),
    .sysref_in(sysref_in), .sysref_ignore(sysref_ignore), .flag_clear(flag_clear),
    .frame_start(frame_start), .mf_start(mf_start), .mf_clk(mf_clk),
    .cfg_err(cfg_err), .locked(locked), .misalign(misalign)
  );

  function automatic bit legal_exp(int f, int k);
    int lo, hi;
    if (f < 1 || f > 256 || k < 1 || k > 256) return 1'b0;
    lo = (17 + f - 1) / f;
    hi = (1024 / f < 256) ? 1024 / f : 256;
    return (k >= lo) && (k <= hi);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock; sample away from the edge, advance the position model
  task automatic tick(bit verify, bit zero);
    int exp_o, act_o;
    @(posedge clk); #2;
    if (zero || !legal_exp(cf, ck)) pos_exp = 0;
    else pos_exp = (pos_exp + 1) % span;
    if (verify) begin
      if (!legal_exp(cf, ck)) exp_o = 0;
      else exp_o = {30'd0, 1'b0} | ((pos_exp % cf == 0) ? 4 : 0)
                 | ((pos_exp == 0) ? 2 : 0) | ((pos_exp < span / 2) ? 1 : 0);
      act_o = {29'd0, frame_start, mf_start, mf_clk};
      check(act_o == exp_o, "R2 R3 R4 R5 {frame_start,mf_start,mf_clk}", act_o, exp_o);
    end
  endtask

  task automatic set_cfg(int f, int k);
    bit changed;
    changed = (f != cf) || (k != ck);
    cf = f; ck = k; span = f * k;
    cfg_f = 9'(f); cfg_k = 9'(k);
    tick(1'b1, changed);
  endtask

  task automatic sysref_low();
    sysref_in = 1'b0;
    repeat (3) tick(1'b1, 1'b0);
  endtask

  task automatic wait_pos(int p);
    while (pos_exp != p) tick(1'b1, 1'b0);
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sysref_in = 1'b0; sysref_ignore = 1'b0; flag_clear = 1'b0;
    cfg_f = 9'd2; cfg_k = 9'd10; cf = 2; ck = 10; span = 20;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check(locked == 1'b0, "R7 reset locked", int'(locked), 0);
    check(misalign == 1'b0, "R8 reset misalign", int'(misalign), 0);
    check(cfg_err == 1'b0, "R1 reset cfg_err", int'(cfg_err), 0);
    tick(1'b0, 1'b0);

    // R1/R2: exhaustive legality grid over small F and K
    for (int f = 0; f <= 12; f++) begin
      for (int k = 0; k <= 40; k++) begin
        set_cfg(f, k);
        check(cfg_err == !legal_exp(f, k), "R1 cfg_err grid", int'(cfg_err), int'(!legal_exp(f, k)));
      end
    end
    // R1 corner products and out-of-range values
    begin
      int cf_l[12] = '{256, 256, 1, 1, 4, 5, 5, 257, 300, 1, 1, 128};
      int ck_l[12] = '{4,   5,   256, 257, 256, 204, 205, 1, 3, 16, 17, 8};
      for (int i = 0; i < 12; i++) begin
        set_cfg(cf_l[i], ck_l[i]);
        check(cfg_err == !legal_exp(cf_l[i], ck_l[i]), "R1 cfg_err corner",
              int'(cfg_err), int'(!legal_exp(cf_l[i], ck_l[i])));
      end
    end

    // R3 R4 R5: free-running sweeps, even and odd multiframe lengths
    for (int f = 1; f <= 4; f++) begin
      for (int k = (17 + f - 1) / f; k <= (17 + f - 1) / f + 4; k++) begin
        set_cfg(f, k);
        repeat (2 * span + 2) tick(1'b1, 1'b0);
      end
    end

    // R2: SYSREF has no effect under an illegal configuration
    set_cfg(1, 5);
    sysref_in = 1'b1;
    repeat (3) tick(1'b1, 1'b0);
    check(locked == 1'b0, "R2 locked under cfg_err", int'(locked), 0);
    sysref_low();

    // R6 R7 R8: periodic SYSREF with period equal to the multiframe
    set_cfg(2, 10);
    for (int i = 0; i < 3 * span; i++) begin
      sysref_in = ((i % span) < 4);
      tick(1'b1, i == 2);
      if (i == 2) check(locked == 1'b1, "R6 R7 lock after third edge", int'(locked), 1);
    end
    check(misalign == 1'b0, "R8 aligned periodic SYSREF", int'(misalign), 0);
    sysref_low();

    // R8: misaligned edge realigns and sets the flag
    wait_pos(5);
    sysref_in = 1'b1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b1);
    check(misalign == 1'b1, "R8 misaligned SYSREF", int'(misalign), 1);
    sysref_low();

    // R10: clear
    flag_clear = 1'b1; tick(1'b1, 1'b0); flag_clear = 1'b0;
    check(misalign == 1'b0, "R10 flag_clear", int'(misalign), 0);

    // R9: ignore mode keeps the phase, only the flag updates
    sysref_ignore = 1'b1;
    wait_pos(5);
    sysref_in = 1'b1;
    repeat (3) tick(1'b1, 1'b0);
    check(misalign == 1'b1, "R9 ignore still flags", int'(misalign), 1);
    check(locked == 1'b1, "R9 ignore keeps lock", int'(locked), 1);
    sysref_low();
    repeat (span) tick(1'b1, 1'b0);

    // R10: set wins over a coincident clear
    flag_clear = 1'b1; tick(1'b1, 1'b0); flag_clear = 1'b0;
    check(misalign == 1'b0, "R10 clear before set", int'(misalign), 0);
    wait_pos(5);
    sysref_in = 1'b1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0);
    flag_clear = 1'b1;
    tick(1'b1, 1'b0);
    flag_clear = 1'b0;
    check(misalign == 1'b1, "R10 set wins over clear", int'(misalign), 1);
    sysref_in = 1'b0;
    sysref_ignore = 1'b0;
    repeat (3) tick(1'b1, 1'b0);

    // R11: a K-only change while locked unlocks and restarts
    wait_pos(9);
    sysref_in = 1'b1;
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b1, 1'b1);
    check(locked == 1'b1, "R7 relock", int'(locked), 1);
    sysref_low();
    set_cfg(2, 11);
    check(locked == 1'b0, "R11 K change unlocks", int'(locked), 0);
    repeat (2 * span) tick(1'b1, 1'b0);
    set_cfg(3, 11);
    check(locked == 1'b0, "R11 F change", int'(locked), 0);
    repeat (2 * span) tick(1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule